// File: doc/BRIEF.md
# Chained-Rounding Saturating Multiply-Accumulate

This block is a signed fixed-point multiply-accumulate unit. Each accepted sample multiplies two N-bit two's-complement operands into a full-width 2N-bit product. The product is narrowed to an S-bit term and added into a T-bit accumulator, or loaded into it when the clear control is set. The accumulator is then narrowed twice, first by `ACC_DROP` bits and then by `OUT_DROP` bits. The last value is fitted onto the M-bit output bus. If it does not fit, the output is clamped to a rail and a sticky overflow flag is raised.

All three narrowing points use the mode carried with the sample. The modes are round to nearest, floor, and a ceiling that adds one whole kept LSB. The mode travels down the pipeline with its sample, so back-to-back samples may use different modes. There is one register per stage. A result leaves the block a fixed number of cycles after its operands were accepted, and it is marked by a one-cycle valid pulse. Between results the output and the flag hold their values.

Top module: `rsat_mac`

## Requirements
- R1: While `rst_n` is low, `out_vld`, `dout` and `ovf_flag` are all zero, and the accumulator is emptied.
- R2: A sample accepted at a rising edge with `in_vld` high produces exactly one `out_vld` pulse. The pulse and the result appear after the fifth rising edge, counting the accepting edge as the first. Results leave in acceptance order.
- R3: The 2N-bit product is narrowed to S bits by discarding D1 = 2N+1-S low bits of the sign-extended product. Before the discard, mode 2'b00 (nearest) adds 2^(D1-1), mode 2'b01 (floor) adds nothing, and mode 2'b10 (ceiling) adds 2^D1.
- R4: When `clr_acc` is high with a sample, the accumulator is loaded with that sample's narrowed product. Otherwise the narrowed product is added to the running sum in two's complement.
- R5: The accumulator is narrowed by discarding `ACC_DROP` low bits, using the same add-then-discard rule and the sample's mode.
- R6: That value is narrowed again by discarding `OUT_DROP` low bits under the same rule. If the result lies above 2^(M-1)-1, `dout` is 16'h7FFF. If it lies below -2^(M-1), `dout` is 16'h8000. Otherwise the low M bits are output.
- R7: `ovf_flag` is set by any result that is clamped. It stays set through later in-range results. It is cleared when a result whose sample carried `clr_acc` leaves the block, unless that result is itself clamped.
- R8: Mode 2'b11 behaves exactly as floor at every narrowing point.
- R9: Cycles with `in_vld` low ignore the operand, clear and mode inputs. They leave the accumulator unchanged, and they leave `dout` and `ovf_flag` unchanged.
- R10: Every narrowing point uses the mode sampled with the sample being processed, even when consecutive samples carry different modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Operands, clear and mode are valid this cycle |
| clr_acc | input | 1 | Load the accumulator instead of adding to it |
| rmode | input | 2 | Narrowing mode: 00 nearest, 01 floor, 10 ceiling, 11 floor |
| op_a | input | N | Signed multiplicand |
| op_b | input | N | Signed multiplier |
| out_vld | output | 1 | One-cycle pulse marking a new result |
| dout | output | M | Saturated signed result |
| ovf_flag | output | 1 | Sticky clamp indicator |

## Verification
Every result is due exactly five rising edges after the edge that accepted its sample. The bench stamps each expected result with the cycle count at acceptance plus five and compares it on the falling edge of the due cycle, so a result that arrives early, late or not at all is reported. On cycles without a pulse, the bench checks that `dout` and `ovf_flag` still equal the last expected result. This covers the ignored-input rule and the sticky flag between results.

// File: rtl/mac_pkg.sv
package mac_pkg;
    typedef enum logic [1:0] {
        RM_NEAR  = 2'b00,
        RM_FLOOR = 2'b01,
        RM_CEIL  = 2'b10,
        RM_SPARE = 2'b11
    } rmode_e;
endpackage

// File: rtl/mac_round.sv
// Narrows a signed value by DROP bits: add a mode-dependent increment, then discard.
module mac_round
    import mac_pkg::*;
#(
    parameter int W    = 32,
    parameter int DROP = 9
) (
    input  logic [W-1:0]      din,
    input  rmode_e            mode,
    output logic [W-DROP:0]   dout
);
    localparam int WX = W + 1;

    logic [WX-1:0] ext;
    logic [WX-1:0] inc;
    logic [WX-1:0] sum;

    always_comb begin
        ext = {din[W-1], din};
        inc = '0;
        unique case (mode)
            RM_NEAR:  inc[DROP-1] = 1'b1;
            RM_CEIL:  inc[DROP]   = 1'b1;
            default:  inc         = '0;
        endcase
        sum  = ext + inc;
        dout = sum[WX-1:DROP];
    end
endmodule

// File: rtl/mac_accum.sv
// Accumulator register: load or add a sign-extended term on each enabled cycle.
module mac_accum #(
    parameter int S = 24,
    parameter int T = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         load,
    input  logic [S-1:0] term,
    output logic [T-1:0] acc
);
    logic [T-1:0] term_x;

    always_comb term_x = {{(T-S){term[S-1]}}, term};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc <= '0;
        else if (en)
            acc <= load ? term_x : acc + term_x;
    end
endmodule

// File: rtl/mac_sat.sv
// Fits a signed W-bit value onto M bits, clamping to a rail when guard bits disagree.
module mac_sat #(
    parameter int W = 34,
    parameter int M = 16
) (
    input  logic [W-1:0] din,
    output logic [M-1:0] dout,
    output logic         clip
);
    logic [W-M:0] guard;
    logic         fits;

    always_comb begin
        guard = din[W-1:M-1];
        fits  = (&guard) | ~(|guard);
        clip  = ~fits;
        if (fits)
            dout = din[M-1:0];
        else if (din[W-1])
            dout = {1'b1, {(M-1){1'b0}}};
        else
            dout = {1'b0, {(M-1){1'b1}}};
    end
endmodule

// File: rtl/rsat_mac.sv
module rsat_mac
    import mac_pkg::*;
#(
    parameter int N        = 16,
    parameter int S        = 24,
    parameter int T        = 40,
    parameter int M        = 16,
    parameter int ACC_DROP = 4,
    parameter int OUT_DROP = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic         clr_acc,
    input  logic [1:0]   rmode,
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    output logic         out_vld,
    output logic [M-1:0] dout,
    output logic         ovf_flag
);
    localparam int P  = 2 * N;
    localparam int D1 = P + 1 - S;
    localparam int W2 = T + 1 - ACC_DROP;
    localparam int W3 = W2 + 1 - OUT_DROP;

    // Stage A: full-width product
    logic          a_vld, a_clr;
    rmode_e        a_mode;
    logic [P-1:0]  a_prod;
    // Stage B: product narrowed to S
    logic          b_vld, b_clr;
    rmode_e        b_mode;
    logic [S-1:0]  b_term;
    // Stage C: accumulator
    logic          c_vld, c_clr;
    rmode_e        c_mode;
    logic [T-1:0]  c_acc;
    // Stage D: accumulator narrowed
    logic          d_vld, d_clr;
    rmode_e        d_mode;
    logic [W2-1:0] d_val;

    logic [S-1:0]  r1;
    logic [W2-1:0] r2;
    logic [W3-1:0] r3;
    logic [M-1:0]  sat_val;
    logic          sat_clip;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_vld  <= 1'b0;
            a_clr  <= 1'b0;
            a_mode <= RM_NEAR;
            a_prod <= '0;
        end else begin
            a_vld <= in_vld;
            if (in_vld) begin
                a_clr  <= clr_acc;
                a_mode <= rmode_e'(rmode);
                a_prod <= $signed(op_a) * $signed(op_b);
            end
        end
    end

    mac_round #(.W(P), .DROP(D1)) u_rnd_prod (
        .din  (a_prod),
        .mode (a_mode),
        .dout (r1)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_vld  <= 1'b0;
            b_clr  <= 1'b0;
            b_mode <= RM_NEAR;
            b_term <= '0;
        end else begin
            b_vld <= a_vld;
            if (a_vld) begin
                b_clr  <= a_clr;
                b_mode <= a_mode;
                b_term <= r1;
            end
        end
    end

    mac_accum #(.S(S), .T(T)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (b_vld),
        .load  (b_clr),
        .term  (b_term),
        .acc   (c_acc)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_vld  <= 1'b0;
            c_clr  <= 1'b0;
            c_mode <= RM_NEAR;
        end else begin
            c_vld <= b_vld;
            if (b_vld) begin
                c_clr  <= b_clr;
                c_mode <= b_mode;
            end
        end
    end

    mac_round #(.W(T), .DROP(ACC_DROP)) u_rnd_acc (
        .din  (c_acc),
        .mode (c_mode),
        .dout (r2)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_vld  <= 1'b0;
            d_clr  <= 1'b0;
            d_mode <= RM_NEAR;
            d_val  <= '0;
        end else begin
            d_vld <= c_vld;
            if (c_vld) begin
                d_clr  <= c_clr;
                d_mode <= c_mode;
                d_val  <= r2;
            end
        end
    end

    mac_round #(.W(W2), .DROP(OUT_DROP)) u_rnd_out (
        .din  (d_val),
        .mode (d_mode),
        .dout (r3)
    );

    mac_sat #(.W(W3), .M(M)) u_sat (
        .din  (r3),
        .dout (sat_val),
        .clip (sat_clip)
    );

    // Stage E: output bus and sticky flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            dout     <= '0;
            ovf_flag <= 1'b0;
        end else begin
            out_vld <= d_vld;
            if (d_vld) begin
                dout     <= sat_val;
                ovf_flag <= (ovf_flag & ~d_clr) | sat_clip;
            end
        end
    end
endmodule

// File: rtl/rsat_mac_chk.sv
module rsat_mac_chk #(
    parameter int M = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_vld,
    input logic         out_vld,
    input logic [M-1:0] dout,
    input logic         ovf_flag
);
    logic [2:0] since;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            since <= '0;
        else if (since != 3'd7)
            since <= since + 3'd1;
    end

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since >= 3'd5) |-> (out_vld == $past(in_vld, 5)));

    // R9
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since != 3'd0 && !out_vld) |-> $stable(dout));

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since != 3'd0 && !out_vld) |-> $stable(ovf_flag));

    // R6
    rail_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> (dout == {1'b0, {(M-1){1'b1}}} || dout == {1'b1, {(M-1){1'b0}}}));
endmodule

bind rsat_mac rsat_mac_chk #(.M(M)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (in_vld),
    .out_vld  (out_vld),
    .dout     (dout),
    .ovf_flag (ovf_flag)
);

// File: tb/rsat_mac_test.sv
`timescale 1ns/1ps
module rsat_mac_test;
    localparam int N = 16, S = 24, T = 40, M = 16, ACC_DROP = 4, OUT_DROP = 4;
    localparam int D1 = 2 * N + 1 - S;
    localparam longint PMAX = (64'sd1 <<< (M - 1)) - 1;
    localparam longint PMIN = -(64'sd1 <<< (M - 1));

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_vld = 1'b0;
    logic         clr_acc = 1'b0;
    logic [1:0]   rmode = 2'b00;
    logic [N-1:0] op_a = '0;
    logic [N-1:0] op_b = '0;
    logic         out_vld;
    logic [M-1:0] dout;
    logic         ovf_flag;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    longint m_acc = 0;
    bit     m_flag = 1'b0;
    longint last_out = 0;
    bit     last_flag = 1'b0;

    longint q_val[$];
    bit     q_flg[$];
    int     q_due[$];
    string  q_req[$];

    rsat_mac #(.N(N), .S(S), .T(T), .M(M), .ACC_DROP(ACC_DROP), .OUT_DROP(OUT_DROP)) uut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .clr_acc(clr_acc), .rmode(rmode),
        .op_a(op_a), .op_b(op_b), .out_vld(out_vld), .dout(dout), .ovf_flag(ovf_flag)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint narrow(input longint x, input int d, input logic [1:0] m);
        longint inc;
        inc = (m == 2'b00) ? (64'sd1 <<< (d - 1)) : (m == 2'b10) ? (64'sd1 <<< d) : 64'sd0;
        return (x + inc) >>> d;
    endfunction

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // One sample (or an idle cycle) driven after a falling edge
    task automatic drive(input bit v, input bit c, input logic [1:0] m,
                         input int a, input int b, input string req);
        longint p, r3, o;
        bit clip;
        @(negedge clk);
        in_vld = v; clr_acc = c; rmode = m;
        op_a = N'(a); op_b = N'(b);
        if (v) begin
            p = longint'($signed(N'(a))) * longint'($signed(N'(b)));
            p = narrow(p, D1, m);
            m_acc = c ? p : m_acc + p;
            m_acc = (m_acc <<< (64 - T)) >>> (64 - T);
            r3 = narrow(narrow(m_acc, ACC_DROP, m), OUT_DROP, m);
            clip = (r3 > PMAX) || (r3 < PMIN);
            o = (r3 > PMAX) ? PMAX : (r3 < PMIN) ? PMIN : r3;
            m_flag = (m_flag & ~c) | clip;
            q_val.push_back(o); q_flg.push_back(m_flag);
            q_due.push_back(cyc + 5); q_req.push_back(req);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b1, 2'b10, 16'h7A5C, 16'h8123, "R9");
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_vld) begin
                if (q_val.size() == 0) begin
                    chk(1'b0, "R2", "unexpected out_vld", 1, 0);
                end else begin
                    longint ev; bit ef; int ed; string er;
                    ev = q_val.pop_front(); ef = q_flg.pop_front();
                    ed = q_due.pop_front(); er = q_req.pop_front();
                    chk(cyc == ed, "R2", "result cycle", cyc, ed);
                    chk(longint'($signed(dout)) == ev, er, "dout", longint'($signed(dout)), ev);
                    chk(ovf_flag == ef, (ef || last_flag) ? "R7" : er, "ovf_flag", ovf_flag, ef);
                    last_out = ev; last_flag = ef;
                end
            end else begin
                chk(longint'($signed(dout)) == last_out, "R9", "dout held", longint'($signed(dout)), last_out);
                chk(ovf_flag == last_flag, "R9", "ovf_flag held", ovf_flag, last_flag);
                if (q_due.size() != 0)
                    chk(cyc < q_due[0], "R2", "late result", cyc, q_due[0]);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 50000);
        finish_run();
    end

    initial begin
        int unsigned seed;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(out_vld == 1'b0, "R1", "out_vld in reset", out_vld, 0);
        chk(dout == '0, "R1", "dout in reset", longint'(dout), 0);
        chk(ovf_flag == 1'b0, "R1", "ovf_flag in reset", ovf_flag, 0);
        @(negedge clk); rst_n = 1'b1;

        // R3, R8: each mode on products with fractional remainders
        drive(1, 1, 2'b00, 300, 7, "R3");
        drive(1, 1, 2'b01, 300, 7, "R3");
        drive(1, 1, 2'b10, 300, 7, "R3");
        drive(1, 1, 2'b11, 300, 7, "R8");
        drive(1, 1, 2'b00, -1234, 2771, "R3");
        drive(1, 1, 2'b01, -1234, 2771, "R3");
        drive(1, 1, 2'b10, -1234, 2771, "R3");
        drive(1, 1, 2'b11, -1234, 2771, "R8");
        drive(1, 1, 2'b10, 1, 1, "R3");
        drive(1, 1, 2'b01, 1, 1, "R3");
        idle(6);

        // R4, R5: load then accumulate, mixed signs
        drive(1, 1, 2'b01, 5000, 3000, "R4");
        drive(1, 0, 2'b01, -2000, 4100, "R4");
        drive(1, 0, 2'b00, 777, 999, "R5");
        drive(1, 0, 2'b10, -31, 17, "R5");
        idle(6);

        // R9: ignored inputs, then a zero add exposes the unchanged sum
        idle(5);
        drive(1, 0, 2'b01, 0, 0, "R9");
        idle(6);

        // R6, R7: positive clamp, sticky flag, clear
        drive(1, 1, 2'b01, -32768, -32768, "R6");
        for (int i = 0; i < 4; i++) drive(1, 0, 2'b01, -32768, -32768, "R6");
        drive(1, 0, 2'b01, 32767, -32768, "R7");
        drive(1, 0, 2'b01, 32767, -32768, "R7");
        idle(6);
        drive(1, 1, 2'b00, 100, 100, "R7");
        idle(6);
        // R6: negative clamp
        drive(1, 1, 2'b01, 32767, -32768, "R6");
        for (int i = 0; i < 5; i++) drive(1, 0, 2'b10, 32767, -32768, "R6");
        drive(1, 1, 2'b10, 40, -3, "R7");
        idle(6);

        // R10: back-to-back samples with changing modes
        drive(1, 1, 2'b00, 1111, 2222, "R10");
        drive(1, 0, 2'b10, -333, 444, "R10");
        drive(1, 0, 2'b01, 555, -666, "R10");
        drive(1, 0, 2'b11, 7777, 8, "R10");
        drive(1, 0, 2'b00, -9, -9999, "R10");
        idle(6);

        // Mixed traffic
        seed = 32'h1D2C3B4A;
        for (int i = 0; i < 400; i++) begin
            int a, b;
            seed = seed * 32'd1103515245 + 32'd12345;
            a = int'($signed(seed[31:16])) >>> seed[3:0];
            b = int'($signed(seed[15:0])) >>> seed[7:4];
            drive(seed[9:8] != 2'b00, seed[12:10] == 3'b000, seed[14:13], a, b, "R4");
        end
        idle(10);
        chk(q_due.size() == 0, "R2", "pending results", q_due.size(), 0);
        finish_run();
    end
endmodule